// File: doc/BRIEF.md
# Activity-Adaptive Scan Shift Rate Governor

This block paces the shifting of a scan chain of `CHAIN_LEN` flip-flops from a fast reference clock. It emits a one-cycle shift strobe every `k` reference cycles, where `k` is drawn from `NUM_RATES` settings. The slowest setting (`k = NUM_RATES`) is the power-safe worst case. The fastest setting (`k = 1`) is the full rate the shift structure allows. The block starts at the slowest setting because the contents of the chain are unknown at that point.

On every strobe the governor looks at the bit entering the chain and the bit leaving it. A bit equal to the bit shifted just before it on the same stream is a non-transition, and it adds no switching activity. A saturating counter tracks how many non-transitions the chain currently holds. The counter rises when one enters and falls when one leaves. The rate level is that count divided by `CHAIN_LEN/NUM_RATES`, capped at the top level. A quiet chain therefore shifts faster, and the rate falls back as the quiet data drains out.

A capture request returns the governor to its start state: slowest rate, empty count and no stream history.

Top module: `scan_rate_governor`

## Requirements
- R1: After reset `rate_lvl` is 0, `shift_en` is low, and the first strobe comes in the `NUM_RATES`-th reference cycle after reset is released.
- R2: `shift_en` is a one-cycle pulse. With level `L` applied, consecutive strobes are exactly `NUM_RATES - L` reference cycles apart, so level 0 is the slowest rate and level `NUM_RATES-1` gives a strobe every cycle.
- R3: A non-transition is a strobed bit that equals the previous strobed bit of the same stream. The first bit of each stream after reset or capture is never counted.
- R4: The activity count rises by one when only the input stream has a non-transition and falls by one when only the output stream has one. It saturates at 0 and at `CHAIN_LEN-1`.
- R5: `rate_lvl` changes only on a strobe edge or on a capture. A newly chosen level sets the spacing of the next strobe interval.
- R6: At each strobe the new level is min(updated count / (`CHAIN_LEN/NUM_RATES`), `NUM_RATES-1`). The level therefore moves by at most one step per strobe.
- R7: While `capture_req` is high no strobe is issued. The cycle after a capture has `rate_lvl` = 0, a zero count and empty stream history, and the next strobe follows `NUM_RATES` cycles after the capture cycle.
- R8: When both streams show a non-transition on the same strobe, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_req | input | 1 | Capture request; returns the governor to its start state |
| scan_in_bit | input | 1 | Bit entering the chain on the current strobe |
| scan_out_bit | input | 1 | Bit leaving the chain on the current strobe |
| shift_en | output | 1 | One-cycle shift strobe |
| rate_lvl | output | $clog2(NUM_RATES) | Applied rate level (0 = slowest) |

## Verification
The bench tries to count the history-less first bit after a capture. A design that made this mistake would reach the next level one shift too early. It drives the count past the ceiling and then drains it. A counter that does not saturate would hold too high a level after the drain. It also pushes the count below zero, where a counter that wraps would jump straight to the fastest rate. Simultaneous entry and exit of non-transitions must leave the level unchanged. Every strobe gap is timed against the level in force, so a reload of the divider in mid-interval or off by one shows up as a wrong spacing.

// File: rtl/scg_pkg.sv
package scg_pkg;

  // Level chosen from the chain's non-transition count.
  function automatic int level_of(int count, int chain_len, int n_rates);
    int step;
    int lvl;
    step = chain_len / n_rates;
    if (step < 1) step = 1;
    lvl = count / step;
    if (lvl > n_rates - 1) lvl = n_rates - 1;
    return lvl;
  endfunction

  // Reference cycles between strobes at a given level.
  function automatic int period_of(int lvl, int n_rates);
    return n_rates - lvl;
  endfunction

endpackage

// File: rtl/scg_edge_watch.sv
module scg_edge_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift,
  input  logic bit_i,
  output logic same_o
);
  logic prev_q;
  logic have_prev_q;

  // Non-transition: strobed bit equals the previous strobed bit.
  assign same_o = shift && have_prev_q && (bit_i == prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (shift) begin
      prev_q      <= bit_i;
      have_prev_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scg_activity.sv
module scg_activity #(
  parameter int CHAIN_LEN = 16,
  localparam int CNT_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CHAIN_LEN - 1);

  always_comb begin
    cnt_nxt = cnt_q;
    if (inc && !dec && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else                 cnt_q <= cnt_nxt;
  end

  p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !clear) |=> cnt_q == CNT_MAX);
  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !clear) |=> cnt_q == '0);
  p_hold_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/scg_rate_div.sv
module scg_rate_div #(
  parameter int NUM_RATES = 4,
  localparam int IDX_W = $clog2(NUM_RATES),
  localparam int PER_W = $clog2(NUM_RATES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] target_lvl,
  output logic             strobe,
  output logic [IDX_W-1:0] lvl_q
);
  import scg_pkg::*;

  logic [PER_W-1:0] tick_q;
  logic [PER_W-1:0] period;

  assign period = PER_W'(period_of(int'(lvl_q), NUM_RATES));
  assign strobe = (tick_q == period - 1'b1) && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tick_q <= '0;
      lvl_q  <= '0;
    end else if (strobe) begin
      tick_q <= '0;
      lvl_q  <= target_lvl;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  p_change_at_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(strobe) || $past(clear)));
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (int'(lvl_q) == int'($past(lvl_q)) ||
                int'(lvl_q) == int'($past(lvl_q)) + 1 ||
                int'(lvl_q) == int'($past(lvl_q)) - 1));
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && int'(target_lvl) < NUM_RATES - 1) |=> !strobe);
endmodule

// File: rtl/scan_rate_governor.sv
module scan_rate_governor #(
  parameter int CHAIN_LEN = 16,
  parameter int NUM_RATES = 4,
  localparam int CNT_W = $clog2(CHAIN_LEN),
  localparam int IDX_W = $clog2(NUM_RATES),
  localparam int PER_W = $clog2(NUM_RATES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_req,
  input  logic             scan_in_bit,
  input  logic             scan_out_bit,
  output logic             shift_en,
  output logic [IDX_W-1:0] rate_lvl
);
  import scg_pkg::*;

  // Stream 0 = entering the chain, stream 1 = leaving it.
  logic [1:0]       stream_bit;
  logic [1:0]       stream_same;
  logic             in_same;
  logic             out_same;
  logic             act_inc;
  logic             act_dec;
  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] act_nxt;
  logic [IDX_W-1:0] target_lvl;

  assign stream_bit = {scan_out_bit, scan_in_bit};

  for (genvar s = 0; s < 2; s++) begin : g_watch
    scg_edge_watch u_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (capture_req),
      .shift  (shift_en),
      .bit_i  (stream_bit[s]),
      .same_o (stream_same[s])
    );
  end

  assign in_same  = stream_same[0];
  assign out_same = stream_same[1];
  assign act_inc  = in_same;
  assign act_dec  = out_same;

  scg_activity #(.CHAIN_LEN(CHAIN_LEN)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (capture_req),
    .inc     (act_inc),
    .dec     (act_dec),
    .cnt_q   (act_cnt),
    .cnt_nxt (act_nxt)
  );

  assign target_lvl = IDX_W'(level_of(int'(act_nxt), CHAIN_LEN, NUM_RATES));

  scg_rate_div #(.NUM_RATES(NUM_RATES)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (capture_req),
    .target_lvl (target_lvl),
    .strobe     (shift_en),
    .lvl_q      (rate_lvl)
  );

  // Independent gap monitor for the strobe spacing check.
  logic [PER_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || capture_req || shift_en) gap_q <= '0;
    else if (int'(gap_q) < NUM_RATES)      gap_q <= gap_q + 1'b1;
  end

  p_min_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> int'(gap_q) >= NUM_RATES - int'(rate_lvl) - 1);
  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_req |=> (!in_same && !out_same));
  p_capture_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_req |=> (rate_lvl == '0 && act_cnt == '0));
endmodule

// File: tb/scan_rate_governor_test.sv
module scan_rate_governor_test;
  localparam int N = 16;
  localparam int M = 4;
  localparam int IW = $clog2(M);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture_req = 1'b0;
  logic scan_in_bit = 1'b0;
  logic scan_out_bit = 1'b0;
  logic shift_en;
  logic [IW-1:0] rate_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  int m_cnt = 0;
  int m_lvl = 0;
  bit m_vi = 0, m_vo = 0, m_pi = 0, m_po = 0;
  bit last_in = 0, last_out = 0;

  // Stimulus table: {in pattern, out pattern}, shifted LSB first.
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'h5555},
    {16'hFFFF, 16'hFFFF},
    {16'hAAAA, 16'h0000},
    {16'h00FF, 16'h0F0F},
    {16'hFFFF, 16'hAAAA},
    {16'hAAAA, 16'hFFFF}
  };

  scan_rate_governor #(.CHAIN_LEN(N), .NUM_RATES(M)) uut (
    .clk(clk), .rst_n(rst_n), .capture_req(capture_req),
    .scan_in_bit(scan_in_bit), .scan_out_bit(scan_out_bit),
    .shift_en(shift_en), .rate_lvl(rate_lvl)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_level(int cnt);
    int l = 0;
    while (l < M - 1 && cnt >= (l + 1) * (N / M)) l++;
    return l;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_lvl = 0; m_vi = 0; m_vo = 0;
  endtask

  // Called at a not-yet-sampled negedge; returns at the negedge after the strobe.
  task automatic do_shift(input bit i, input bit o);
    int n = 0;
    int exp_p = M - m_lvl;
    bit ni, no;
    scan_in_bit = i;
    scan_out_bit = o;
    for (int c = 0; c < 2 * M + 2; c++) begin
      n++;
      if (shift_en) break;
      @(negedge clk);
    end
    check("R2 strobe spacing", n, exp_p);
    ni = m_vi && (i == m_pi);
    no = m_vo && (o == m_po);
    if (ni && !no && m_cnt < N - 1) m_cnt++;
    else if (no && !ni && m_cnt > 0) m_cnt--;
    m_pi = i; m_po = o; m_vi = 1; m_vo = 1;
    m_lvl = model_level(m_cnt);
    last_in = i; last_out = o;
    @(negedge clk);
    check("R6 level after strobe", int'(rate_lvl), m_lvl);
  endtask

  task automatic burst(input int n, input bit in_same, input bit out_same);
    for (int k = 0; k < n; k++)
      do_shift(in_same ? last_in : ~last_in, out_same ? last_out : ~last_out);
  endtask

  task automatic do_capture();
    capture_req = 1'b1;
    #1;
    check("R7 no strobe during capture", int'(shift_en), 0);
    @(negedge clk);
    capture_req = 1'b0;
    model_reset();
    check("R7 slowest level after capture", int'(rate_lvl), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset level", int'(rate_lvl), 0);
    check("R1 no strobe at reset", int'(shift_en), 0);
    do_shift(1'b0, 1'b0); // first gap equals M (R1)

    for (int v = 0; v < NVEC; v++)
      for (int b = 0; b < 16; b++)
        do_shift(VEC[v][16 + b], VEC[v][b]);

    // R7: capture returns to slowest rate; next gap is M
    do_capture();
    // R3: four equal bits after capture count as three
    burst(4, 1'b1, 1'b0);
    check("R3 first bit not counted", int'(rate_lvl), 0);
    burst(1, 1'b1, 1'b0);
    check("R6 step at threshold", int'(rate_lvl), 1);
    // R8: both streams quiet -> count holds at 4
    burst(5, 1'b1, 1'b1);
    check("R8 hold on simultaneous", int'(rate_lvl), 1);
    // R4 floor: drain past zero, then refill to 4
    burst(6, 1'b0, 1'b1);
    check("R4 floor level", int'(rate_lvl), 0);
    burst(4, 1'b1, 1'b0);
    check("R4 floor saturates", int'(rate_lvl), 1);
    // R4 ceiling: overfill, then drain 4 -> count 11
    burst(20, 1'b1, 1'b0);
    check("R4 ceiling level", int'(rate_lvl), M - 1);
    burst(4, 1'b0, 1'b1);
    check("R4 ceiling saturates", int'(rate_lvl), 2);
    // R7 at fastest rate: capture suppresses the every-cycle strobe
    burst(8, 1'b1, 1'b0);
    check("R2 fastest level", int'(rate_lvl), M - 1);
    do_capture();
    do_shift(1'b0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule